// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block counts core activity for profiling. It has one free-running cycle counter and two event counters, all 32 bits wide. Each event counter watches one line of a vector of single-cycle event strobes from the core. An 8-bit selector per counter picks that line. One 32-bit control word is reached through a small register port. It holds the global enable, the counter reset strobes, a divide-by-64 mode for the cycle counter, the per-counter interrupt enables, sticky overflow flags and both selectors.

Software preloads a counter with a start value so that it wraps after a chosen number of counts. A wrap raises that counter's overflow flag. Any flag whose interrupt enable is set holds the level interrupt output high. To clear the flags, software writes back the control word it has just read: each overflow bit written as 1 is cleared.

Register map (2-bit address): 0 = control word, 1 = cycle counter, 2 = event counter 0, 3 = event counter 1. Reads are combinational from current state. A write takes effect at the clock edge where `reg_we_i` is high.

Top module: `evt_pmu`

## Requirements
- R1: While control bit 0 (enable) is 0, no counter changes except by a register write. Counting uses the enable value held before the current edge.
- R2: A control write with bit 1 set clears both event counters. A control write with bit 2 set clears the cycle counter and the divider. Bits 1 and 2 always read back as 0.
- R3: With enable set and bit 3 clear, the cycle counter adds one at every clock edge.
- R4: With enable and bit 3 set, the cycle counter adds one only on every 64th edge after the divider was cleared.
- R5: Bits 19:12 select the strobe line for event counter 0, and bits 27:20 select it for event counter 1. With enable set, an event counter adds one at each edge where its selected line is high.
- R6: Overflow flags sit at bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter). A flag is set when its counter wraps from all ones to zero, and it stays set until it is cleared.
- R7: Writing 1 to an overflow bit clears that flag, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R8: Bits 7, 11 and 31:28 ignore writes and read as 0.
- R9: Interrupt enables sit at bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter). `irq_o` is high exactly when some overflow flag and its enable are both set.
- R10: An event counter whose selector is 0xFF, or any value at or above the strobe vector width, never counts.
- R11: Addresses 1, 2 and 3 read and write the cycle counter, event counter 0 and event counter 1. A write there wins over a count in the same cycle.
- R12: After reset the control word reads 0x0FFFF000 (both selectors 0xFF, all else 0), every counter reads 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| evt_i | input | NUM_EVT | Event strobes from the core |
| irq_o | output | 1 | Level interrupt |

## Verification
A fault in the enable, divider or selector state shows up as a wrong counter value at the next register read after the edge where the count went wrong. It drifts further with every edge after that. A bad overflow flag shows at once in bits 10:8 of the control word and on `irq_o`, and it stays visible because the flags are sticky. The bench reads back counters after exact known edge counts and places wraps by preloading near all ones. This exposes an error of a single count or a single cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 8;
  localparam int NUM_CNT  = 3;  // index 0,1 = event counters, 2 = cycle counter
  localparam int B_EN     = 0;
  localparam int B_ECLR   = 1;
  localparam int B_CCLR   = 2;
  localparam int B_DIV    = 3;
  localparam int B_IE     = 4;
  localparam int B_OV     = 8;
  localparam int B_SEL0   = 12;
  localparam int B_SEL1   = 20;
  localparam logic [SEL_W-1:0] SEL_OFF = 8'hFF;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CYC  = 2'd1,
    A_EV0  = 2'd2,
    A_EV1  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = inc_i && !load_i && !clr_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R6: a wrap leaves the counter at zero
  p_wrap_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  // R11: preload value lands regardless of counting
  p_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
  parameter int NUM_EVT = 24,
  parameter int SEL_W   = 8
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_i == SEL_W'(i) && sel_i != {SEL_W{1'b1}}) hit_o = evt_i[i];
    end
  end
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [REG_W-1:0]        wdata_i,
  input  logic [NUM_CNT-1:0]      wrap_i,
  output logic                    en_o,
  output logic                    div_o,
  output logic [NUM_CNT-1:0]      ie_o,
  output logic [NUM_CNT-1:0]      ov_o,
  output logic [1:0][SEL_W-1:0]   sel_o,
  output logic                    evt_clr_o,
  output logic                    cyc_clr_o,
  output logic [REG_W-1:0]        ctrl_o
);
  logic                  en_q, div_q;
  logic [NUM_CNT-1:0]    ie_q, ov_q, ov_clr;
  logic [1:0][SEL_W-1:0] sel_q;
  logic                  unused_wz;

  assign unused_wz = ^{wdata_i[7], wdata_i[11], wdata_i[31:28]};
  assign ov_clr    = we_i ? wdata_i[B_OV +: NUM_CNT] : '0;
  assign evt_clr_o = we_i & wdata_i[B_ECLR];
  assign cyc_clr_o = we_i & wdata_i[B_CCLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      div_q <= 1'b0;
      ie_q  <= '0;
      ov_q  <= '0;
      sel_q <= {SEL_OFF, SEL_OFF};
    end else begin
      if (we_i) begin
        en_q     <= wdata_i[B_EN];
        div_q    <= wdata_i[B_DIV];
        ie_q     <= wdata_i[B_IE +: NUM_CNT];
        sel_q[0] <= wdata_i[B_SEL0 +: SEL_W];
        sel_q[1] <= wdata_i[B_SEL1 +: SEL_W];
      end
      ov_q <= (ov_q & ~ov_clr) | wrap_i;  // set wins over clear
    end
  end

  assign en_o  = en_q;
  assign div_o = div_q;
  assign ie_o  = ie_q;
  assign ov_o  = ov_q;
  assign sel_o = sel_q;

  always_comb begin
    ctrl_o                      = '0;
    ctrl_o[B_EN]                = en_q;
    ctrl_o[B_DIV]               = div_q;
    ctrl_o[B_IE +: NUM_CNT]     = ie_q;
    ctrl_o[B_OV +: NUM_CNT]     = ov_q;
    ctrl_o[B_SEL0 +: SEL_W]     = sel_q[0];
    ctrl_o[B_SEL1 +: SEL_W]     = sel_q[1];
  end

  // R6: flags are sticky without a write
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ((ov_q & $past(ov_q)) == $past(ov_q)));
  // R7: a wrap always leaves its flag set, even against a clear
  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrap_i) |=> ((ov_q & $past(wrap_i)) == $past(wrap_i)));
endmodule

// File: rtl/evt_pmu.sv
module evt_pmu
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 24,
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  logic                       en, div, evt_clr, cyc_clr, ctrl_we, tick;
  logic [NUM_CNT-1:0]         ie, ov, wrap, inc, load, clr;
  logic [1:0][SEL_W-1:0]      sel;
  logic [1:0]                 hit;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [REG_W-1:0]           ctrl_rd;
  logic [DIV_LOG2-1:0]        pre_q;

  assign ctrl_we = reg_we_i && (reg_addr_i == A_CTRL);

  pmu_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .we_i(ctrl_we), .wdata_i(reg_wdata_i), .wrap_i(wrap),
    .en_o(en), .div_o(div), .ie_o(ie), .ov_o(ov), .sel_o(sel),
    .evt_clr_o(evt_clr), .cyc_clr_o(cyc_clr), .ctrl_o(ctrl_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pre_q <= '0;
    else if (cyc_clr)    pre_q <= '0;
    else if (en && div)  pre_q <= pre_q + 1'b1;
  end
  assign tick = !div || (&pre_q);

  for (genvar e = 0; e < 2; e++) begin : g_sel
    pmu_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
      .sel_i(sel[e]), .evt_i(evt_i), .hit_o(hit[e])
    );
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam logic [1:0] MY_ADDR = (g == 0) ? A_EV0 : (g == 1) ? A_EV1 : A_CYC;
    if (g < 2) begin : g_evt
      assign inc[g] = en && hit[g];
      assign clr[g] = evt_clr;
    end else begin : g_cyc
      assign inc[g] = en && tick;
      assign clr[g] = cyc_clr;
    end
    assign load[g] = reg_we_i && (reg_addr_i == MY_ADDR);
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .load_i(load[g]), .load_val_i(reg_wdata_i[CNT_W-1:0]),
      .clr_i(clr[g]), .inc_i(inc[g]),
      .cnt_o(cnt[g]), .wrap_o(wrap[g])
    );
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_rd;
      A_CYC:   reg_rdata_o = REG_W'(cnt[2]);
      A_EV0:   reg_rdata_o = REG_W'(cnt[0]);
      default: reg_rdata_o = REG_W'(cnt[1]);
    endcase
  end

  assign irq_o = |(ov & ie);

  // R1: disabled and untouched counters hold
  p_gate_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !reg_we_i) |=> $stable(cnt));
  // R4: divided cycle counter holds between ticks
  p_div_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && div && !(&pre_q) && !reg_we_i) |=> $stable(cnt[2]));
  // R9: an enabled wrap raises the interrupt next cycle
  p_irq_raise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(wrap & ie)) && !reg_we_i) |=> irq_o);
  // R10: unused selector never counts
  p_unused_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel[0] == SEL_OFF) && !reg_we_i) |=> $stable(cnt[0]));
endmodule

// File: tb/evt_pmu_bench.sv
`timescale 1ns/10ps
module evt_pmu_bench;
  localparam int NUM_EVT = 24;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2, OP_Q = 2'd3;

  typedef struct packed {
    logic [1:0]         op;
    logic [1:0]         addr;
    logic [31:0]        data;
    logic [NUM_EVT-1:0] evt;
    logic [3:0]         req;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VEC [NV] = '{
    '{OP_R, 2'd0, 32'h0FFFF000, 24'h0, 4'd12},  // R12 reset control
    '{OP_R, 2'd1, 32'h0,        24'h0, 4'd12},  // R12
    '{OP_R, 2'd2, 32'h0,        24'h0, 4'd12},  // R12
    '{OP_Q, 2'd0, 32'h0,        24'h0, 4'd12},  // R12 irq low
    '{OP_W, 2'd0, 32'h00503000, 24'h0, 4'd5},   // R5 sel0=3 sel1=5
    '{OP_R, 2'd0, 32'h00503000, 24'h0, 4'd5},
    '{OP_I, 2'd0, 32'd5,        24'h000028, 4'd1}, // R1 disabled
    '{OP_R, 2'd1, 32'h0,        24'h0, 4'd1},
    '{OP_R, 2'd2, 32'h0,        24'h0, 4'd1},
    '{OP_W, 2'd0, 32'h00503001, 24'h0, 4'd1},   // R1 enable
    '{OP_I, 2'd0, 32'd10,       24'h000008, 4'd5},
    '{OP_W, 2'd0, 32'h00503000, 24'h0, 4'd1},
    '{OP_R, 2'd1, 32'd11,       24'h0, 4'd3},   // R3 every edge
    '{OP_R, 2'd2, 32'd10,       24'h0, 4'd5},   // R5 selected line
    '{OP_R, 2'd3, 32'd0,        24'h0, 4'd5},
    '{OP_W, 2'd0, 32'hF0503880, 24'h0, 4'd8},   // R8 write-as-zero
    '{OP_R, 2'd0, 32'h00503000, 24'h0, 4'd8},
    '{OP_W, 2'd0, 32'h00503002, 24'h0, 4'd2},   // R2 event reset
    '{OP_R, 2'd2, 32'h0,        24'h0, 4'd2},
    '{OP_R, 2'd1, 32'd11,       24'h0, 4'd2},
    '{OP_R, 2'd0, 32'h00503000, 24'h0, 4'd2},
    '{OP_W, 2'd0, 32'h00503004, 24'h0, 4'd2},   // R2 cycle reset
    '{OP_R, 2'd1, 32'h0,        24'h0, 4'd2},
    '{OP_W, 2'd1, 32'hFFFFFFFD, 24'h0, 4'd11},  // R11 preload
    '{OP_R, 2'd1, 32'hFFFFFFFD, 24'h0, 4'd11},
    '{OP_W, 2'd3, 32'hFFFFFFFE, 24'h0, 4'd11},
    '{OP_W, 2'd0, 32'h005FF071, 24'h0, 4'd6},
    '{OP_I, 2'd0, 32'd3,        24'hFFFFFF, 4'd6},
    '{OP_W, 2'd0, 32'h005FF070, 24'h0, 4'd6},
    '{OP_R, 2'd1, 32'd1,        24'h0, 4'd6},   // R6 cycle wrapped
    '{OP_R, 2'd3, 32'd1,        24'h0, 4'd6},   // R6 event wrapped
    '{OP_R, 2'd2, 32'd0,        24'h0, 4'd10},  // R10 sel 0xFF
    '{OP_R, 2'd0, 32'h005FF670, 24'h0, 4'd6},
    '{OP_Q, 2'd0, 32'h1,        24'h0, 4'd9},   // R9
    '{OP_W, 2'd0, 32'h005FF270, 24'h0, 4'd7},   // R7 clear bit 9 only
    '{OP_R, 2'd0, 32'h005FF470, 24'h0, 4'd7},
    '{OP_Q, 2'd0, 32'h1,        24'h0, 4'd9},
    '{OP_W, 2'd0, 32'h005FF030, 24'h0, 4'd9},   // R9 mask cycle irq
    '{OP_Q, 2'd0, 32'h0,        24'h0, 4'd9},
    '{OP_R, 2'd0, 32'h005FF430, 24'h0, 4'd7},
    '{OP_W, 2'd0, 32'h005FF430, 24'h0, 4'd7},
    '{OP_R, 2'd0, 32'h005FF030, 24'h0, 4'd7},
    '{OP_W, 2'd0, 32'h005FF00D, 24'h0, 4'd4},   // R4 divided mode
    '{OP_I, 2'd0, 32'd63,       24'h0, 4'd4},
    '{OP_R, 2'd1, 32'd0,        24'h0, 4'd4},
    '{OP_I, 2'd0, 32'd1,        24'h0, 4'd4},
    '{OP_R, 2'd1, 32'd1,        24'h0, 4'd4},
    '{OP_W, 2'd0, 32'h005FF000, 24'h0, 4'd4},
    '{OP_R, 2'd1, 32'd1,        24'h0, 4'd4}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               we = 1'b0;
  logic [1:0]         addr = '0;
  logic [31:0]        wdata = '0;
  logic [31:0]        rdata;
  logic [NUM_EVT-1:0] evt = '0;
  logic               irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_pmu #(.NUM_EVT(NUM_EVT)) u_evt_pmu (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic do_write(input logic [1:0] a, input logic [31:0] d, input logic [NUM_EVT-1:0] e);
    we = 1'b1; addr = a; wdata = d; evt = e;
    @(posedge clk); @(negedge clk);
    we = 1'b0; evt = '0;
  endtask

  task automatic do_idle(input int n, input logic [NUM_EVT-1:0] e);
    evt = e;
    repeat (n) @(posedge clk);
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int r);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] a, input logic [31:0] exp, input int r);
    addr = a; #0.05;
    chk(rdata, exp, r);
  endtask

  task automatic do_irq(input logic exp, input int r);
    #0.05;
    chk({31'b0, irq}, {31'b0, exp}, r);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    foreach (VEC[i]) begin
      case (VEC[i].op)
        OP_W: do_write(VEC[i].addr, VEC[i].data, VEC[i].evt);
        OP_R: do_read(VEC[i].addr, VEC[i].data, int'(VEC[i].req));
        OP_I: do_idle(int'(VEC[i].data), VEC[i].evt);
        default: do_irq(VEC[i].data[0], int'(VEC[i].req));
      endcase
    end
    // R7 corner: wrap and clear of the same flag in one cycle
    do_write(2'd2, 32'hFFFFFFFF, '0);
    do_write(2'd0, 32'h00002001, '0);
    do_write(2'd0, 32'h00002101, 24'h000004);
    do_read(2'd0, 32'h00002101, 7);
    do_read(2'd2, 32'h0, 6);
    do_write(2'd0, 32'h00002100, '0);
    do_read(2'd0, 32'h00002000, 7);
    // R12: reset in mid-run
    do_write(2'd0, 32'h00002161, '0);
    do_idle(2, 24'h000004);
    rst_n = 1'b0;
    do_read(2'd0, 32'h0FFFF000, 12);
    do_read(2'd2, 32'h0, 12);
    do_read(2'd1, 32'h0, 12);
    do_irq(1'b0, 12);
    @(negedge clk); rst_n = 1'b1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule